// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 64-bit virtual address into a physical address by reading a three-level page table held in memory. A request carries the virtual address, the kind of access (read, write or execute) and whether the access comes from user or kernel mode. The walker first screens the address for correct sign extension and for the direct-mapped kernel window. It then reads one 64-bit entry per level over a single-outstanding memory read port and uses the frame number of each intermediate entry as the base of the next table. At the last level it applies the validity, permission and fault-on checks.

Pages are 8 KB, so the offset is 13 bits and every level index is 10 bits. The walker returns a three-bit result code, the physical address and the size of the mapped region in address bits. A granularity hint in the final entry widens that region. Two table base page numbers are supplied as inputs: a normal one, and a system one that is chosen when a bound comparison is enabled and the address is at or above the bound input.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready` is 1, `done` is 0 and `mem_req_valid` is 0.
- R2: A request is taken only while `req_ready` is high, and `req_ready` is high only when no walk is in progress. A `req_valid` seen during a walk is ignored. Each walk ends with `done` high for exactly one cycle, and `result`, `pa` and `region_bits` are valid in that cycle.
- R3: If bits 63 down to 42 of the address are not all equal (a non-canonical address), the result is 1 (not valid) and no memory read is issued.
- R4: An address with bits 42:41 equal to 2'b10 is in the direct-mapped kernel window, and no memory read is issued for it. In kernel mode (`req_user`=0) the result is 0, `pa` equals the virtual address and `region_bits` is 13. In user mode the result is 2 (access violation). Addresses in the other three segments are walked.
- R5: The entry address is (base page number << 13) + 8 × index. The level-1 index is VA[42:33], the level-2 index is VA[32:23] and the level-3 index is VA[22:13]. The frame number in entry bits 63:32 becomes the base for the next level, and a successful walk makes three reads.
- R6: If `vbound_en` is 1 and the address is greater than or equal to `vbound`, the walk starts from `sys_tbl_base`. Otherwise it starts from `tbl_base`.
- R7: If a level-1 or level-2 entry has bit 0 (valid) clear, the walk stops at once with result 1 and makes no further reads.
- R8: The level-3 permission bits are: bit 13 user write, bit 12 kernel write, bit 9 user read, bit 8 kernel read. The access codes are 0 = read, 1 = write, 2 = execute. User mode checks the user bits and kernel mode checks the kernel bits. A write needs the write bit, and reads and executes need the read bit. If the needed bit is clear, the result is 2.
- R9: Fault-on bits are bit 1 (read), bit 2 (write) and bit 3 (execute). A bit takes effect only for its own access type. The results are 3 for fault-on-read, 5 for fault-on-write and 4 for fault-on-execute.
- R10: At level 3 a clear valid bit gives 1 and takes precedence over an access violation (2). An access violation takes precedence over any fault-on result.
- R11: On result 0 after a walk, `pa` is (frame number << 13) | VA[12:0] and `region_bits` is 13 + 3 × the granularity hint in entry bits 6:5. On any nonzero result, `pa` and `region_bits` are 0.
- R12: At most one memory read is outstanding. `mem_req_valid` and `mem_req_addr` stay constant until `mem_req_ready` is high, and every entry address is 8-byte aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and accepting a request |
| req_va | input | 64 | Virtual address |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| req_user | input | 1 | 1 = user mode, 0 = kernel mode |
| tbl_base | input | 32 | Normal level-1 table page number |
| sys_tbl_base | input | 32 | System level-1 table page number |
| vbound_en | input | 1 | Enables the bound comparison |
| vbound | input | 64 | Bound address for system table selection |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 64 | Entry byte address |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 64 | Entry quadword |
| done | output | 1 | One-cycle completion pulse |
| result | output | 3 | Result code |
| pa | output | 64 | Physical address |
| region_bits | output | 7 | Mapped region size in address bits |

## Verification
A corrupted level counter or index select shows up at the ports as a wrong entry address on `mem_req_addr`, within one read of the fault. It also shows as a wrong read count before `done`, because each test loads only the entries a correct walk would touch and every other location reads as invalid. A wrong base latched from an intermediate entry leads the next read into unmapped memory, so the walk ends with result 1 instead of 0 on the same walk. Faults in the final checks appear in the `result`/`pa`/`region_bits` triple in the `done` cycle, and the tests cover every pairing of mode, access type and enable bit that separates the priority levels.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [2:0] {
        RES_OK      = 3'd0,
        RES_INVALID = 3'd1,
        RES_ACV     = 3'd2,
        RES_FO_RD   = 3'd3,
        RES_FO_EX   = 3'd4,
        RES_FO_WR   = 3'd5
    } res_e;

    typedef enum logic [1:0] {
        ACC_RD = 2'd0,
        ACC_WR = 2'd1,
        ACC_EX = 2'd2
    } acc_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_ISSUE,
        ST_WAIT
    } st_e;

    // Entry bit positions (decoded by the level-3 evaluator)
    localparam int BIT_VALID = 0;
    localparam int BIT_FO_RD = 1;
    localparam int BIT_FO_WR = 2;
    localparam int BIT_FO_EX = 3;
    localparam int BIT_GH_LO = 5;
    localparam int BIT_KRD   = 8;
    localparam int BIT_URD   = 9;
    localparam int BIT_KWR   = 12;
    localparam int BIT_UWR   = 13;
    localparam int BIT_PFN   = 32;

    localparam logic [1:0] SEG_KDIRECT = 2'b10;

endpackage

// File: rtl/ptw_va_decode.sv
module ptw_va_decode #(
    parameter int VA_BITS   = 43,
    parameter int PAGE_BITS = 13,
    parameter int LEVELS    = 3,
    localparam int IDX_W    = PAGE_BITS - 3
) (
    input  logic [63:0]                   va,
    output logic                          canonical,
    output logic [1:0]                    seg,
    output logic [LEVELS-1:0][IDX_W-1:0]  idx,
    output logic [PAGE_BITS-1:0]          offset
);
    localparam int EXT_W = 64 - VA_BITS + 1;

    logic [EXT_W-1:0] ext;

    always_comb begin
        ext       = va[63:VA_BITS-1];
        canonical = (&ext) | ~(|ext);
        seg       = va[VA_BITS-1:VA_BITS-2];
        offset    = va[PAGE_BITS-1:0];
    end

    // idx[0] is the last level, idx[LEVELS-1] the first
    for (genvar g = 0; g < LEVELS; g++) begin : g_idx
        assign idx[g] = va[PAGE_BITS + g*IDX_W +: IDX_W];
    end

endmodule

// File: rtl/ptw_pte_eval.sv
module ptw_pte_eval
    import ptw_pkg::*;
#(
    parameter int PAGE_BITS = 13,
    parameter int PFN_W     = 32,
    parameter int REG_W     = 7
) (
    input  logic [63:0]       pte,
    input  logic [1:0]        acc,
    input  logic              user,
    output res_e              code,
    output logic [PFN_W-1:0]  pfn,
    output logic [REG_W-1:0]  region
);
    logic       rd_en;
    logic       wr_en;
    logic       perm_ok;
    logic       fo_hit;
    logic [1:0] gh;

    always_comb begin
        rd_en   = user ? pte[BIT_URD] : pte[BIT_KRD];
        wr_en   = user ? pte[BIT_UWR] : pte[BIT_KWR];
        perm_ok = (acc == ACC_WR) ? wr_en : rd_en;
        fo_hit  = ((acc == ACC_RD) && pte[BIT_FO_RD]) ||
                  ((acc == ACC_WR) && pte[BIT_FO_WR]) ||
                  ((acc == ACC_EX) && pte[BIT_FO_EX]);
        gh      = pte[BIT_GH_LO +: 2];
        pfn     = pte[BIT_PFN +: PFN_W];
        region  = REG_W'(PAGE_BITS) + REG_W'(3 * gh);

        if (!pte[BIT_VALID]) begin
            code = RES_INVALID;
        end else if (!perm_ok) begin
            code = RES_ACV;
        end else if (fo_hit) begin
            case (acc)
                ACC_RD:  code = RES_FO_RD;
                ACC_WR:  code = RES_FO_WR;
                default: code = RES_FO_EX;
            endcase
        end else begin
            code = RES_OK;
        end
    end

endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import ptw_pkg::*;
#(
    parameter int VA_BITS   = 43,
    parameter int PAGE_BITS = 13,
    parameter int PFN_W     = 32,
    parameter int REG_W     = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [63:0]       req_va,
    input  logic [1:0]        req_acc,
    input  logic              req_user,
    input  logic [PFN_W-1:0]  tbl_base,
    input  logic [PFN_W-1:0]  sys_tbl_base,
    input  logic              vbound_en,
    input  logic [63:0]       vbound,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [63:0]       mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [63:0]       mem_rsp_data,
    output logic              done,
    output logic [2:0]        result,
    output logic [63:0]       pa,
    output logic [REG_W-1:0]  region_bits
);
    localparam int         LEVELS   = 3;
    localparam int         IDX_W    = PAGE_BITS - 3;
    localparam logic [1:0] LAST_LVL = 2'(LEVELS - 1);

    typedef struct packed {
        st_e              st;
        logic [63:0]      va;
        logic [1:0]       acc;
        logic             user;
        logic [PFN_W-1:0] base;
        logic [1:0]       lvl;
        logic [63:0]      addr;
        logic             done;
        res_e             result;
        logic [63:0]      pa;
        logic [REG_W-1:0] region;
    } walk_t;

    walk_t r_q, r_d;

    logic                         canonical;
    logic [1:0]                   seg;
    logic [LEVELS-1:0][IDX_W-1:0] idx;
    logic [PAGE_BITS-1:0]         offset;

    res_e             leaf_code;
    logic [PFN_W-1:0] rsp_pfn;
    logic [REG_W-1:0] leaf_region;

    logic [1:0]       lvl_next;
    logic [IDX_W-1:0] idx_first;
    logic [IDX_W-1:0] idx_next;
    logic             use_sys;
    logic [PFN_W-1:0] start_base;

    ptw_va_decode #(
        .VA_BITS   (VA_BITS),
        .PAGE_BITS (PAGE_BITS),
        .LEVELS    (LEVELS)
    ) u_dec (
        .va        (r_q.va),
        .canonical (canonical),
        .seg       (seg),
        .idx       (idx),
        .offset    (offset)
    );

    ptw_pte_eval #(
        .PAGE_BITS (PAGE_BITS),
        .PFN_W     (PFN_W),
        .REG_W     (REG_W)
    ) u_eval (
        .pte       (mem_rsp_data),
        .acc       (r_q.acc),
        .user      (r_q.user),
        .code      (leaf_code),
        .pfn       (rsp_pfn),
        .region    (leaf_region)
    );

    function automatic logic [63:0] entry_addr(input logic [PFN_W-1:0] b,
                                               input logic [IDX_W-1:0] ix);
        return (64'(b) << PAGE_BITS) + (64'(ix) << 3);
    endfunction

    always_comb begin
        lvl_next   = r_q.lvl + 2'd1;
        idx_first  = idx[LAST_LVL];
        idx_next   = idx[LAST_LVL - lvl_next];
        use_sys    = vbound_en && (r_q.va >= vbound);
        start_base = use_sys ? sys_tbl_base : tbl_base;
    end

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.va   = req_va;
                    r_d.acc  = req_acc;
                    r_d.user = req_user;
                    r_d.st   = ST_CHECK;
                end
            end
            ST_CHECK: begin
                if (!canonical) begin
                    r_d.st     = ST_IDLE;
                    r_d.done   = 1'b1;
                    r_d.result = RES_INVALID;
                    r_d.pa     = '0;
                    r_d.region = '0;
                end else if (seg == SEG_KDIRECT) begin
                    r_d.st     = ST_IDLE;
                    r_d.done   = 1'b1;
                    r_d.result = r_q.user ? RES_ACV : RES_OK;
                    r_d.pa     = r_q.user ? '0 : r_q.va;
                    r_d.region = r_q.user ? '0 : REG_W'(PAGE_BITS);
                end else begin
                    r_d.base = start_base;
                    r_d.lvl  = '0;
                    r_d.addr = entry_addr(start_base, idx_first);
                    r_d.st   = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                if (mem_req_ready) begin
                    r_d.st = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    if (r_q.lvl != LAST_LVL) begin
                        if (!mem_rsp_data[BIT_VALID]) begin
                            r_d.st     = ST_IDLE;
                            r_d.done   = 1'b1;
                            r_d.result = RES_INVALID;
                            r_d.pa     = '0;
                            r_d.region = '0;
                        end else begin
                            r_d.base = rsp_pfn;
                            r_d.lvl  = lvl_next;
                            r_d.addr = entry_addr(rsp_pfn, idx_next);
                            r_d.st   = ST_ISSUE;
                        end
                    end else begin
                        r_d.st     = ST_IDLE;
                        r_d.done   = 1'b1;
                        r_d.result = leaf_code;
                        if (leaf_code == RES_OK) begin
                            r_d.pa     = (64'(rsp_pfn) << PAGE_BITS) | 64'(offset);
                            r_d.region = leaf_region;
                        end else begin
                            r_d.pa     = '0;
                            r_d.region = '0;
                        end
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready     = (r_q.st == ST_IDLE);
    assign mem_req_valid = (r_q.st == ST_ISSUE);
    assign mem_req_addr  = r_q.addr;
    assign done          = r_q.done;
    assign result        = r_q.result;
    assign pa            = r_q.pa;
    assign region_bits   = r_q.region;

endmodule

// File: rtl/ptw_checker.sv
module ptw_checker #(
    parameter int REG_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              done,
    input logic [2:0]        result,
    input logic [63:0]       pa,
    input logic [REG_W-1:0]  region_bits,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [63:0]       mem_req_addr
);
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);  // R2

    AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready);  // R2

    AST_MEM_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));  // R12

    AST_ENTRY_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[2:0] == 3'b000));  // R5

    AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (result <= 3'd5));  // R9

    AST_FAIL_ZEROED: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result != 3'd0) |-> (pa == 64'd0 && region_bits == '0));  // R11

    AST_OK_REGION: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result == 3'd0) |-> (region_bits >= REG_W'(13) && region_bits <= REG_W'(22)));  // R11

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (req_ready && !done && !mem_req_valid));  // R1

endmodule

bind pt_walker ptw_checker #(.REG_W(REG_W)) u_ptw_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_ready     (req_ready),
    .done          (done),
    .result        (result),
    .pa            (pa),
    .region_bits   (region_bits),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr)
);

// File: tb/tb_pt_walker.sv
`timescale 1ns/1ps
module tb_pt_walker;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_ready;
    logic [63:0] req_va;
    logic [1:0]  req_acc;
    logic        req_user;
    logic [31:0] tbl_base;
    logic [31:0] sys_tbl_base;
    logic        vbound_en;
    logic [63:0] vbound;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [63:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [63:0] mem_rsp_data;
    logic        done;
    logic [2:0]  result;
    logic [63:0] pa;
    logic [6:0]  region_bits;

    always #4 clk = ~clk;

    pt_walker dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_va(req_va), .req_acc(req_acc), .req_user(req_user),
        .tbl_base(tbl_base), .sys_tbl_base(sys_tbl_base),
        .vbound_en(vbound_en), .vbound(vbound),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .done(done), .result(result),
        .pa(pa), .region_bits(region_bits)
    );

    // entry bits, per R5/R8/R9/R11
    localparam logic [63:0] V   = 64'h1;
    localparam logic [63:0] FR  = 64'h2;
    localparam logic [63:0] FW  = 64'h4;
    localparam logic [63:0] FX  = 64'h8;
    localparam logic [63:0] KR  = 64'h100;
    localparam logic [63:0] UR  = 64'h200;
    localparam logic [63:0] KW  = 64'h1000;
    localparam logic [63:0] UW  = 64'h2000;

    logic [63:0] mem [logic [63:0]];
    int          n_checks = 0;
    int          n_fail   = 0;
    int          n_reads  = 0;
    int          stall    = 0;
    int          stall_err = 0;
    logic [63:0] rd_addr;

    function automatic logic [63:0] mk_pte(input logic [31:0] pfn, input logic [63:0] bits,
                                           input int gh);
        return ({pfn, 32'h0}) | bits | (64'(gh) << 5);
    endfunction

    function automatic logic [63:0] mk_va(input int l1, input int l2, input int l3,
                                          input int off);
        return (64'(l1) << 33) | (64'(l2) << 23) | (64'(l3) << 13) | 64'(off);
    endfunction

    function automatic logic [63:0] ent(input logic [31:0] base, input int ix);
        return (64'(base) << 13) + 64'(ix) * 8;
    endfunction

    task automatic chk(input bit ok, input string req, input string msg);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s", req, msg);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    // memory responder: one read at a time, optional stall before ready
    initial begin
        mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        forever begin
            @(negedge clk);
            if (mem_req_valid) begin
                rd_addr = mem_req_addr;
                for (int i = 0; i < stall; i++) begin
                    @(negedge clk);
                    if (!mem_req_valid || mem_req_addr !== rd_addr) stall_err++;
                end
                mem_req_ready = 1'b1;
                n_reads++;
                @(negedge clk);
                mem_req_ready = 1'b0;
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = mem.exists(rd_addr) ? mem[rd_addr] : 64'h0;
                @(negedge clk);
                mem_rsp_valid = 1'b0;
            end
        end
    end

    task automatic run_walk(input logic [63:0] va, input logic [1:0] acc, input logic usr,
                            input logic [2:0] e_code, input logic [63:0] e_pa,
                            input logic [6:0] e_bits, input int e_reads, input string req);
        int  cyc;
        bit  busy_ok;
        @(negedge clk);
        n_reads   = 0;
        req_va    = va;
        req_acc   = acc;
        req_user  = usr;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 0;
        busy_ok = 1'b1;
        while (!done && cyc < 300) begin
            if (req_ready) busy_ok = 1'b0;
            @(negedge clk);
            cyc++;
        end
        chk(done === 1'b1 && result === e_code && pa === e_pa && region_bits === e_bits, req,
            $sformatf("va=%h code=%0d pa=%h bits=%0d exp code=%0d pa=%h bits=%0d",
                      va, result, pa, region_bits, e_code, e_pa, e_bits));
        chk(n_reads == e_reads, req,
            $sformatf("va=%h reads=%0d exp %0d", va, n_reads, e_reads));
        @(negedge clk);
        chk(busy_ok && done === 1'b0, "R2",
            $sformatf("busy_ok=%0b done_after=%0b exp 1/0", busy_ok, done));
    endtask

    localparam logic [31:0] BASE  = 32'h10;
    localparam logic [31:0] SBASE = 32'h11;

    task automatic t_reset();
        chk(req_ready === 1'b1 && done === 1'b0 && mem_req_valid === 1'b0, "R1",
            $sformatf("ready=%0b done=%0b mvalid=%0b exp 1/0/0", req_ready, done, mem_req_valid));
    endtask

    // main mapping: l1=1 l2=2 l3=3
    task automatic t_basic();
        logic [63:0] va = mk_va(1, 2, 3, 'h123);
        mem[ent(32'h30, 3)] = mk_pte(32'hABCD, V | KR | KW, 0);
        run_walk(va, 2'd0, 1'b0, 3'd0, (64'hABCD << 13) | 64'h123, 7'd13, 3, "R5");
        mem[ent(32'h30, 3)] = mk_pte(32'h1234, V | KR, 3);
        run_walk(va, 2'd0, 1'b0, 3'd0, (64'h1234 << 13) | 64'h123, 7'd22, 3, "R11");
        mem[ent(32'h30, 3)] = mk_pte(32'h55, V | KR, 1);
        run_walk(va, 2'd2, 1'b0, 3'd0, (64'h55 << 13) | 64'h123, 7'd16, 3, "R11");
    endtask

    task automatic t_perm();
        logic [63:0] va = mk_va(1, 2, 3, 'h7);
        mem[ent(32'h30, 3)] = mk_pte(32'h9, V | KR | KW, 0);
        run_walk(va, 2'd0, 1'b1, 3'd2, 64'h0, 7'd0, 3, "R8");
        mem[ent(32'h30, 3)] = mk_pte(32'h9, V | UR | KW, 0);
        run_walk(va, 2'd1, 1'b1, 3'd2, 64'h0, 7'd0, 3, "R8");
        run_walk(va, 2'd1, 1'b0, 3'd0, (64'h9 << 13) | 64'h7, 7'd13, 3, "R8");
        mem[ent(32'h30, 3)] = mk_pte(32'h9, V | UW, 0);
        run_walk(va, 2'd1, 1'b1, 3'd0, (64'h9 << 13) | 64'h7, 7'd13, 3, "R8");
        run_walk(va, 2'd2, 1'b1, 3'd2, 64'h0, 7'd0, 3, "R8");
    endtask

    task automatic t_faulton();
        logic [63:0] va = mk_va(1, 2, 3, 'h40);
        mem[ent(32'h30, 3)] = mk_pte(32'h8, V | KR | KW | FR, 0);
        run_walk(va, 2'd0, 1'b0, 3'd3, 64'h0, 7'd0, 3, "R9");
        run_walk(va, 2'd1, 1'b0, 3'd0, (64'h8 << 13) | 64'h40, 7'd13, 3, "R9");
        mem[ent(32'h30, 3)] = mk_pte(32'h8, V | KR | KW | FW, 0);
        run_walk(va, 2'd1, 1'b0, 3'd5, 64'h0, 7'd0, 3, "R9");
        run_walk(va, 2'd0, 1'b0, 3'd0, (64'h8 << 13) | 64'h40, 7'd13, 3, "R9");
        mem[ent(32'h30, 3)] = mk_pte(32'h8, V | KR | FX, 0);
        run_walk(va, 2'd2, 1'b0, 3'd4, 64'h0, 7'd0, 3, "R9");
        mem[ent(32'h30, 3)] = mk_pte(32'h8, V | KR | FR | FW, 0);
        run_walk(va, 2'd2, 1'b0, 3'd0, (64'h8 << 13) | 64'h40, 7'd13, 3, "R9");
    endtask

    task automatic t_priority();
        logic [63:0] va = mk_va(1, 2, 3, 'h1);
        mem[ent(32'h30, 3)] = mk_pte(32'h8, FR, 0);
        run_walk(va, 2'd0, 1'b1, 3'd1, 64'h0, 7'd0, 3, "R10");
        mem[ent(32'h30, 3)] = mk_pte(32'h8, V | FR, 0);
        run_walk(va, 2'd0, 1'b1, 3'd2, 64'h0, 7'd0, 3, "R10");
    endtask

    task automatic t_mid_invalid();
        run_walk(mk_va(5, 2, 3, 0), 2'd0, 1'b0, 3'd1, 64'h0, 7'd0, 1, "R7");
        run_walk(mk_va(1, 7, 3, 0), 2'd0, 1'b0, 3'd1, 64'h0, 7'd0, 2, "R7");
        // segment 3 is walked: l1 index 0x300 is unmapped
        run_walk(64'hFFFF_FE00_0000_0000, 2'd0, 1'b0, 3'd1, 64'h0, 7'd0, 1, "R4");
    endtask

    task automatic t_canon();
        run_walk(64'h0000_0800_0000_0000, 2'd0, 1'b0, 3'd1, 64'h0, 7'd0, 0, "R3");
        run_walk(64'h8000_0000_0000_0000, 2'd0, 1'b0, 3'd1, 64'h0, 7'd0, 0, "R3");
    endtask

    task automatic t_kseg();
        run_walk(64'hFFFF_FC00_0000_1234, 2'd1, 1'b0, 3'd0, 64'hFFFF_FC00_0000_1234,
                 7'd13, 0, "R4");
        run_walk(64'hFFFF_FC00_0000_1234, 2'd0, 1'b1, 3'd2, 64'h0, 7'd0, 0, "R4");
    endtask

    task automatic t_vbound();
        logic [63:0] va = mk_va(2, 1, 4, 'h55);
        mem[ent(SBASE, 2)]   = mk_pte(32'h50, V, 0);
        mem[ent(32'h50, 1)]  = mk_pte(32'h51, V, 0);
        mem[ent(32'h51, 4)]  = mk_pte(32'h777, V | KR, 0);
        vbound_en = 1'b1;
        vbound    = 64'h4_0000_0000;
        run_walk(va, 2'd0, 1'b0, 3'd0, (64'h777 << 13) | 64'h55, 7'd13, 3, "R6");
        vbound = va;
        run_walk(va, 2'd0, 1'b0, 3'd0, (64'h777 << 13) | 64'h55, 7'd13, 3, "R6");
        vbound = va + 1;
        run_walk(va, 2'd0, 1'b0, 3'd1, 64'h0, 7'd0, 1, "R6");
        vbound    = 64'h0;
        vbound_en = 1'b0;
        run_walk(va, 2'd0, 1'b0, 3'd1, 64'h0, 7'd0, 1, "R6");
    endtask

    task automatic t_stall();
        logic [63:0] va = mk_va(1, 2, 3, 'h3);
        mem[ent(32'h30, 3)] = mk_pte(32'h42, V | KR, 0);
        stall_err = 0;
        stall = 3;
        run_walk(va, 2'd0, 1'b0, 3'd0, (64'h42 << 13) | 64'h3, 7'd13, 3, "R12");
        stall = 0;
        chk(stall_err == 0, "R12", $sformatf("request changed while stalled %0d times, exp 0", stall_err));
    endtask

    // a request raised during a walk must be ignored
    task automatic t_busy_ignore();
        logic [63:0] va = mk_va(1, 2, 3, 'h10);
        int cyc;
        int dones;
        mem[ent(32'h30, 3)] = mk_pte(32'h66, V | KR, 0);
        @(negedge clk);
        n_reads = 0;
        req_va = va; req_acc = 2'd0; req_user = 1'b0; req_valid = 1'b1;
        @(negedge clk);
        req_va = 64'h0000_0800_0000_0000;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 0;
        while (!done && cyc < 300) begin
            @(negedge clk);
            cyc++;
        end
        chk(result === 3'd0 && pa === ((64'h66 << 13) | 64'h10), "R2",
            $sformatf("code=%0d pa=%h exp 0 %h", result, pa, (64'h66 << 13) | 64'h10));
        dones = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (done) dones++;
        end
        chk(dones == 0 && n_reads == 3, "R2",
            $sformatf("extra dones=%0d reads=%0d exp 0 3", dones, n_reads));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, exp completion");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        req_valid = 1'b0;
        req_va = '0;
        req_acc = '0;
        req_user = 1'b0;
        tbl_base = BASE;
        sys_tbl_base = SBASE;
        vbound_en = 1'b0;
        vbound = '0;
        mem[ent(BASE, 1)]   = mk_pte(32'h20, V, 0);
        mem[ent(32'h20, 2)] = mk_pte(32'h30, V, 0);
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_perm();
        t_faulton();
        t_priority();
        t_mid_invalid();
        t_canon();
        t_kseg();
        t_vbound();
        t_stall();
        t_busy_ignore();
        summary();
        $finish;
    end

endmodule